// File: doc/BRIEF.md
# Interrupt Mask Interval Monitor

This block measures how long an interrupt mask bit stays set. Each channel watches one mask bit and a free-running cycle count. On each sample strobe it opens, extends or closes a measurement interval. When an interval closes, its length (cycle count at the closing sample minus cycle count at the opening sample) updates the shortest, longest and most recent statistics of that channel.

Two channels are built by default. Channel 0 follows the ordinary interrupt mask and channel 1 follows the non-maskable interrupt mask. The two channels share the strobe and the cycle count and nothing else. Readout is continuous. While an interval is open, the block presents its running length and folds that length into the reported longest value. While no interval has yet closed, the reported shortest value is taken from the reported longest value instead of the reset sentinel.

Saturation works as follows. Between two strobes, if the running difference shrinks, the counter has wrapped. The interval is then treated as longer than the counter can express, and its length saturates to all ones. This needs at least one strobe per counter period while an interval is open.

Top module: `imask_monitor`

## Requirements
- R1: After reset every channel reports closed, a running length of 0, last 0 and longest 0. The shortest register holds the all-ones sentinel internally, so the reported shortest value is also 0.
- R2: A strobe with the channel's mask bit at 1 opens a closed channel and captures the cycle count as its start. A strobe with the mask bit at 1 on an already open channel keeps the original start.
- R3: A strobe with the mask bit at 0 on an open channel closes it. The last value becomes the cycle count minus the start, both taken at the respective strobes.
- R4: A closing length replaces the shortest value only if it is smaller, and replaces the longest value only if it is larger.
- R5: Mask changes without a strobe have no effect. A strobe with the mask bit at 0 on a closed channel has no effect.
- R6: While the shortest register still holds its all-ones sentinel, the reported shortest value equals the reported longest value.
- R7: While a channel is open, the reported longest value is the larger of the stored longest value and the running length. Here the running length is the present cycle count minus the start.
- R8: Bit 0 of the mask input drives channel 0 and bit 1 drives channel 1. Each channel keeps its own start and statistics, and activity on one never changes the other.
- R9: If a strobe on an open channel sees a running difference smaller than the one at the previous strobe of that interval, the interval is saturated. Its running length and its closing length are then all ones.
- R10: A closed channel reports a running length of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe; mask bits are examined only when high |
| mask_i | input | NCH | Mask bit per channel (bit 0 ordinary mask, bit 1 non-maskable mask) |
| cycle_i | input | CNT_W | Free-running cycle count |
| min_o | output | NCH x CNT_W | Reported shortest interval per channel |
| max_o | output | NCH x CNT_W | Reported longest interval per channel, including the open interval |
| last_o | output | NCH x CNT_W | Most recent closed interval length per channel |
| open_o | output | NCH | Interval in progress per channel |
| run_len_o | output | NCH x CNT_W | Running length of the open interval, 0 when closed |

## Verification
Two functions can fall in the same cycle. On one strobe, one channel can close its interval while the other channel opens or extends. The very first close of a channel also updates the shortest and longest values together. The bench provokes both with mask patterns 01, 11 and 10 applied on consecutive strobes. A reference model that tracks each channel separately judges every output of both channels after each of those strobes, so any crosstalk or missed dual update shows up.

// File: rtl/imon_pkg.sv
package imon_pkg;

    // Action taken by one channel on the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_OPEN   = 2'd1,
        EV_EXTEND = 2'd2,
        EV_CLOSE  = 2'd3
    } ev_t;

    function automatic ev_t decode_ev(input logic strobe, input logic mask, input logic is_open);
        if (!strobe)
            return EV_IDLE;
        if (mask)
            return is_open ? EV_EXTEND : EV_OPEN;
        return is_open ? EV_CLOSE : EV_IDLE;
    endfunction

    localparam int DEF_CNT_W = 32;
    localparam int DEF_NCH   = 2;

endpackage

// File: rtl/imon_tracker.sv
module imon_tracker
    import imon_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic             mask_i,
    input  logic [CNT_W-1:0] cycle_i,
    output logic             open_o,
    output logic [CNT_W-1:0] run_len_o,
    output logic             close_o,
    output logic [CNT_W-1:0] close_len_o
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic             open_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] prev_q;
    logic             sat_q;

    logic [CNT_W-1:0] delta;
    logic             wrapped;
    logic [CNT_W-1:0] length;
    ev_t              ev;

    always_comb begin
        delta   = cycle_i - start_q;
        wrapped = sat_q || (delta < prev_q);
        length  = wrapped ? ALL1 : delta;
        ev      = decode_ev(strobe_i, mask_i, open_q);
    end

    assign open_o      = open_q;
    assign run_len_o   = open_q ? length : '0;
    assign close_o     = (ev == EV_CLOSE);
    assign close_len_o = length;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            start_q <= '0;
            prev_q  <= '0;
            sat_q   <= 1'b0;
        end else begin
            unique case (ev)
                EV_OPEN: begin
                    open_q  <= 1'b1;
                    start_q <= cycle_i;
                    prev_q  <= '0;
                    sat_q   <= 1'b0;
                end
                EV_EXTEND: begin
                    prev_q <= delta;
                    sat_q  <= wrapped;
                end
                EV_CLOSE: begin
                    open_q <= 1'b0;
                    prev_q <= '0;
                    sat_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    a_r2_open_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && mask_i && !open_q) |=> (open_q && start_q == $past(cycle_i)));

    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && mask_i && open_q) |=> $stable(start_q));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i) |=> ($stable(open_q) && $stable(start_q)));

    a_r3_close_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !mask_i && open_q) |=> !open_q);

    a_r9_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (open_q && sat_q) |-> (run_len_o == ALL1));

    a_r10_closed_zero: assert property (@(posedge clk) disable iff (rst)
        (!open_q) |-> (run_len_o == '0));

endmodule

// File: rtl/imon_stats.sv
module imon_stats
    import imon_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [CNT_W-1:0] min_o,
    output logic [CNT_W-1:0] max_o,
    output logic [CNT_W-1:0] last_o
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] last;
    } stats_t;

    stats_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lo   <= ALL1;
            st_q.hi   <= '0;
            st_q.last <= '0;
        end else if (close_i) begin
            st_q.last <= len_i;
            if (len_i < st_q.lo)
                st_q.lo <= len_i;
            if (len_i > st_q.hi)
                st_q.hi <= len_i;
        end
    end

    assign min_o  = st_q.lo;
    assign max_o  = st_q.hi;
    assign last_o = st_q.last;

    a_r4_lo_le_hi: assert property (@(posedge clk) disable iff (rst)
        (st_q.lo != ALL1) |-> (st_q.lo <= st_q.hi));

    a_r4_lo_never_rises: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.lo <= $past(st_q.lo)));

    a_r4_hi_never_falls: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.hi >= $past(st_q.hi)));

    a_r3_last_hold: assert property (@(posedge clk) disable iff (rst)
        (!close_i) |=> $stable(st_q.last));

endmodule

// File: rtl/imon_readout.sv
module imon_readout
    import imon_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [CNT_W-1:0] run_len_i,
    input  logic [CNT_W-1:0] min_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] rep_min_o,
    output logic [CNT_W-1:0] rep_max_o
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    always_comb begin
        rep_max_o = (open_i && (run_len_i > max_i)) ? run_len_i : max_i;
        rep_min_o = (min_i == ALL1) ? rep_max_o : min_i;
    end

    a_r6_min_le_max: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (rep_min_o <= rep_max_o));

    a_r7_max_covers_run: assert property (@(posedge clk) disable iff (rst)
        open_i |-> (rep_max_o >= run_len_i));

endmodule

// File: rtl/imask_monitor.sv
module imask_monitor
    import imon_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int NCH   = DEF_NCH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_i,
    input  logic [NCH-1:0]             mask_i,
    input  logic [CNT_W-1:0]           cycle_i,
    output logic [NCH-1:0][CNT_W-1:0]  min_o,
    output logic [NCH-1:0][CNT_W-1:0]  max_o,
    output logic [NCH-1:0][CNT_W-1:0]  last_o,
    output logic [NCH-1:0]             open_o,
    output logic [NCH-1:0][CNT_W-1:0]  run_len_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic             close_w;
        logic [CNT_W-1:0] close_len_w;
        logic [CNT_W-1:0] lo_w;
        logic [CNT_W-1:0] hi_w;

        imon_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk        (clk),
            .rst        (rst),
            .strobe_i   (sample_i),
            .mask_i     (mask_i[g]),
            .cycle_i    (cycle_i),
            .open_o     (open_o[g]),
            .run_len_o  (run_len_o[g]),
            .close_o    (close_w),
            .close_len_o(close_len_w)
        );

        imon_stats #(.CNT_W(CNT_W)) u_st (
            .clk    (clk),
            .rst    (rst),
            .close_i(close_w),
            .len_i  (close_len_w),
            .min_o  (lo_w),
            .max_o  (hi_w),
            .last_o (last_o[g])
        );

        imon_readout #(.CNT_W(CNT_W)) u_rd (
            .clk      (clk),
            .rst      (rst),
            .open_i   (open_o[g]),
            .run_len_i(run_len_o[g]),
            .min_i    (lo_w),
            .max_i    (hi_w),
            .rep_min_o(min_o[g]),
            .rep_max_o(max_o[g])
        );
    end

endmodule

// File: tb/sim_imask_monitor.sv
`timescale 1ns/1ps
module sim_imask_monitor;
    localparam int W = 8;
    localparam int N = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst;
    logic                 sample;
    logic [N-1:0]         mask;
    logic [W-1:0]         cyc;
    logic [N-1:0][W-1:0]  min_o, max_o, last_o, run_o;
    logic [N-1:0]         open_o;

    imask_monitor #(.CNT_W(W), .NCH(N)) u0 (
        .clk(clk), .rst(rst), .sample_i(sample), .mask_i(mask), .cycle_i(cyc),
        .min_o(min_o), .max_o(max_o), .last_o(last_o), .open_o(open_o), .run_len_o(run_o)
    );

    typedef struct {
        string    tag;
        int       ch;
        logic [W-1:0] mn, mx, ls, rl;
        logic     op;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state per channel
    logic         m_open [N];
    logic [W-1:0] m_start[N], m_prev[N], m_min[N], m_max[N], m_last[N];
    logic         m_sat  [N];

    task automatic cmp(input string tag, input string fld, input int ch,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d %s actual=%0d expected=%0d", tag, ch, fld, got, exp);
        end
    endtask

    // Monitor: compares mid-cycle what the driver pushed just after the edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "min",  e.ch, min_o[e.ch],  e.mn);
            cmp(e.tag, "max",  e.ch, max_o[e.ch],  e.mx);
            cmp(e.tag, "last", e.ch, last_o[e.ch], e.ls);
            cmp(e.tag, "run",  e.ch, run_o[e.ch],  e.rl);
            cmp(e.tag, "open", e.ch, {{(W-1){1'b0}}, open_o[e.ch]}, {{(W-1){1'b0}}, e.op});
        end
    end

    // Driver: applies one strobe/mask/count, pushes the outputs expected now
    task automatic tick(input logic s, input logic [N-1:0] m, input int adv, input string tag);
        @(posedge clk);
        #1;
        sample = s;
        mask   = m;
        cyc    = cyc + W'(adv);
        for (int ch = 0; ch < N; ch++) begin
            exp_t e;
            logic [W-1:0] d, run, rmax;
            d    = cyc - m_start[ch];
            run  = !m_open[ch] ? '0 : ((m_sat[ch] || d < m_prev[ch]) ? '1 : d);
            rmax = (m_open[ch] && run > m_max[ch]) ? run : m_max[ch];
            e.tag = tag; e.ch = ch;
            e.rl = run; e.mx = rmax; e.ls = m_last[ch]; e.op = m_open[ch];
            e.mn = (m_min[ch] == '1) ? rmax : m_min[ch];
            q.push_back(e);
        end
        for (int ch = 0; ch < N; ch++) begin
            logic [W-1:0] d, len;
            d = cyc - m_start[ch];
            if (s && m[ch] && !m_open[ch]) begin
                m_open[ch] = 1'b1; m_start[ch] = cyc; m_prev[ch] = '0; m_sat[ch] = 1'b0;
            end else if (s && m[ch] && m_open[ch]) begin
                if (d < m_prev[ch]) m_sat[ch] = 1'b1;
                m_prev[ch] = d;
            end else if (s && !m[ch] && m_open[ch]) begin
                len = (m_sat[ch] || d < m_prev[ch]) ? '1 : d;
                if (len < m_min[ch]) m_min[ch] = len;
                if (len > m_max[ch]) m_max[ch] = len;
                m_last[ch] = len;
                m_open[ch] = 1'b0; m_prev[ch] = '0; m_sat[ch] = 1'b0;
            end
        end
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; sample = 1'b0; mask = '0; cyc = '0;
        for (int ch = 0; ch < N; ch++) begin
            m_open[ch] = 1'b0; m_start[ch] = '0; m_prev[ch] = '0;
            m_min[ch] = '1; m_max[ch] = '0; m_last[ch] = '0; m_sat[ch] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R10: reset state, sentinel min folded to 0
        tick(0, 2'b00, 1, "R1");
        tick(0, 2'b00, 1, "R10");
        // R5: mask without strobe, and strobe with mask 0 on closed channel
        tick(0, 2'b11, 1, "R5");
        tick(0, 2'b11, 1, "R5");
        tick(1, 2'b00, 1, "R5");
        tick(0, 2'b00, 1, "R5");
        // R2: open channel 0
        tick(1, 2'b01, 1, "R2");
        // R7: running length folded into reported max while open, R6 min follows
        tick(0, 2'b00, 3, "R7");
        tick(0, 2'b10, 3, "R6");
        // R2: strobe with mask still set does not restart
        tick(1, 2'b01, 1, "R2");
        // R3: close, first interval sets min, max and last together
        tick(1, 2'b00, 2, "R3");
        tick(0, 2'b00, 1, "R3");
        // R4: shorter interval lowers min, max kept
        tick(1, 2'b01, 1, "R4");
        tick(1, 2'b00, 2, "R4");
        tick(0, 2'b00, 1, "R4");
        // R4: longer interval raises max, min kept
        tick(1, 2'b01, 1, "R4");
        tick(0, 2'b00, 5, "R7");
        tick(1, 2'b00, 5, "R4");
        tick(0, 2'b00, 1, "R4");
        // R8: channels opening/closing on the same strobes
        tick(1, 2'b10, 1, "R8");
        tick(1, 2'b11, 2, "R8");
        tick(1, 2'b01, 3, "R8");
        tick(1, 2'b00, 1, "R8");
        tick(0, 2'b00, 1, "R8");
        tick(0, 2'b00, 1, "R10");
        // R9: wrap seen between strobes saturates channel 1
        tick(1, 2'b10, 1, "R9");
        tick(1, 2'b10, 200, "R9");
        tick(1, 2'b10, 200, "R9");
        tick(0, 2'b10, 1, "R9");
        tick(1, 2'b00, 1, "R9");
        tick(0, 2'b00, 1, "R9");
        tick(0, 2'b00, 1, "R6");

        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule